// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block manages sixteen general-purpose pins split into two banks of eight. A host reaches it over a plain byte-wide register bus with an address, write data, read data, a write strobe and a read strobe. Every pin has two control registers. The drive register holds the output value, the direction, the open-drain choice and the pull settings. The sense register holds an interrupt edge selector and returns the synchronized pin level.

Incoming pin levels pass through two flops before edge detection. When a pin sees an edge that its selector accepts, the pin's pending bit is set. Pending bits live in one byte per bank and are cleared by writing ones. A mask byte per bank gates which pending bits reach the single combined interrupt output. A second mask byte per bank is plain storage. Pad electrical behaviour stays outside the block: the pull and open-drain settings are only exported as control bits.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset every drive, sense, mask, secondary mask and pending register reads 0x00 and `irq` is low.
- R2: A pin's drive register sits at 0x2B plus the pin index for pins 0-7 and at 0x3B plus (index - 8) for pins 8-15. Bit 0 is the output value, bit 5 the direction (1 = output), bit 4 open-drain (1) or push-pull (0), bit 3 pull enable and bits 2:1 the pull kind (0 strong down, 1 strong up, 2 weak down, 3 weak up). Bits 7:6 read as zero. The settings appear on `pad_od`, `pull_en` and `pull_sel` (two bits per pin, pin i at bits 2i+1:2i).
- R3: `pad_out` follows drive bit 0. `pad_oe` is high only when the direction bit is 1, and in open-drain mode only when bit 0 is also 0.
- R4: A pin's sense register sits at 0x33 plus the index for pins 0-7 and at 0x43 plus (index - 8) for pins 8-15. Bit 0 returns the pin level after a two-flop synchronizer, bits 2:1 hold the edge selector, and bits 7:3 read as zero.
- R5: Edge selector codes are 0 none, 1 falling, 2 rising and 3 both. Only an edge of a selected kind sets the pin's pending bit.
- R6: The pending bytes are at 0x0B (pins 0-7) and 0x0C (pins 8-15), bit k for pin k of the bank. Writing a 1 clears that bit and a 0 leaves it. If an edge and a clear hit one bit in the same cycle, the bit stays set.
- R7: The mask bytes are at 0x19 and 0x1A, where a 1 masks the pin. A masked pin still sets its pending bit. `irq` is high whenever any pending bit is unmasked.
- R8: The secondary mask bytes at 0x1B and 0x1C read back what was written and have no effect on `irq`.
- R9: A read of an unmapped address returns 0x00, and a write to one changes no register.
- R10: `bus_rdata` is registered: it takes the addressed value on the clock edge that samples `bus_rd`, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one register per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Per-pin output value |
| pad_oe | output | 16 | Per-pin output enable |
| pad_od | output | 16 | Per-pin open-drain select |
| pull_en | output | 16 | Per-pin pull enable |
| pull_sel | output | 32 | Per-pin pull kind, two bits per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `bus_wr` and `bus_rd` never target the same address with conflicting meaning in one cycle, and that `pin_in` can change at any time, since the synchronizer absorbs that. The bench drives the bus only at falling clock edges, keeps each strobe high for exactly one cycle, and changes the pins only while no timed clear is in flight, except in the single case built to land an edge and a clear on the same cycle. Pin changes are followed by enough idle cycles for the two synchronizer stages and the edge stage to settle before the pending byte is read.

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*8-1:0] DRV_BASES  = {8'h3B, 8'h2B},
  parameter logic [NUM_BANKS*8-1:0] SNS_BASES  = {8'h43, 8'h33},
  parameter logic [NUM_BANKS*8-1:0] PEND_ADDRS = {8'h0C, 8'h0B},
  parameter logic [NUM_BANKS*8-1:0] MASK_ADDRS = {8'h1A, 8'h19},
  parameter logic [NUM_BANKS*8-1:0] AUX_ADDRS  = {8'h1C, 8'h1B}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [7:0]               bus_addr,
  input  logic [7:0]               bus_wdata,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [7:0]               bus_rdata,
  input  logic [NUM_BANKS*8-1:0]   pin_in,
  output logic [NUM_BANKS*8-1:0]   pad_out,
  output logic [NUM_BANKS*8-1:0]   pad_oe,
  output logic [NUM_BANKS*8-1:0]   pad_od,
  output logic [NUM_BANKS*8-1:0]   pull_en,
  output logic [NUM_BANKS*16-1:0]  pull_sel,
  output logic                     irq
);
  localparam int BANK  = 8;
  localparam int NPINS = NUM_BANKS * BANK;

  function automatic logic [7:0] slot(input logic [NUM_BANKS*8-1:0] bases,
                                      input int b, input int k);
    return bases[b*8 +: 8] + 8'(k);
  endfunction

  logic [5:0]       drv  [NPINS];
  logic [1:0]       mode [NPINS];
  logic [NPINS-1:0] pend, mask, aux;
  logic [NPINS-1:0] sync1, sync2, last;
  logic [NPINS-1:0] hit, clr;
  logic [7:0]       rd_mux;
  logic             mapped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++)
      hit[p] = (mode[p][1] & sync2[p] & ~last[p]) |
               (mode[p][0] & ~sync2[p] & last[p]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPINS; p++) begin
        drv[p]  <= '0;
        mode[p] <= '0;
      end
      mask <= '0;
      aux  <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        for (int k = 0; k < BANK; k++) begin
          if (bus_addr == slot(DRV_BASES, b, k)) drv[b*BANK+k]  <= bus_wdata[5:0];
          if (bus_addr == slot(SNS_BASES, b, k)) mode[b*BANK+k] <= bus_wdata[2:1];
        end
        if (bus_addr == slot(MASK_ADDRS, b, 0)) mask[b*BANK +: BANK] <= bus_wdata;
        if (bus_addr == slot(AUX_ADDRS, b, 0))  aux[b*BANK +: BANK]  <= bus_wdata;
      end
    end
  end

  always_comb begin
    clr = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (bus_wr && bus_addr == slot(PEND_ADDRS, b, 0))
        clr[b*BANK +: BANK] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | hit;
  end

  assign irq = |(pend & ~mask);

  always_comb begin
    rd_mux = '0;
    mapped = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < BANK; k++) begin
        if (bus_addr == slot(DRV_BASES, b, k)) begin
          rd_mux = {2'b00, drv[b*BANK+k]};
          mapped = 1'b1;
        end
        if (bus_addr == slot(SNS_BASES, b, k)) begin
          rd_mux = {5'b0, mode[b*BANK+k], sync2[b*BANK+k]};
          mapped = 1'b1;
        end
      end
      if (bus_addr == slot(PEND_ADDRS, b, 0)) begin
        rd_mux = pend[b*BANK +: BANK];
        mapped = 1'b1;
      end
      if (bus_addr == slot(MASK_ADDRS, b, 0)) begin
        rd_mux = mask[b*BANK +: BANK];
        mapped = 1'b1;
      end
      if (bus_addr == slot(AUX_ADDRS, b, 0)) begin
        rd_mux = aux[b*BANK +: BANK];
        mapped = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  genvar gp;
  generate
    for (gp = 0; gp < NPINS; gp++) begin : g_pin
      assign pad_out[gp]           = drv[gp][0];
      assign pad_od[gp]            = drv[gp][4];
      assign pull_en[gp]           = drv[gp][3];
      assign pull_sel[2*gp +: 2]   = drv[gp][2:1];
      assign pad_oe[gp]            = drv[gp][5] & ~(drv[gp][4] & drv[gp][0]);

      p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit[gp] |=> pend[gp])
        else $error("selected edge did not set pending bit");

      p_idle_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend[gp] && mode[gp] == 2'b00) |=> !pend[gp])
        else $error("pending set with detection off");

      p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[gp] && !clr[gp]) |=> pend[gp])
        else $error("pending bit dropped without a clear");

      p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[gp] && !hit[gp]) |=> !pend[gp])
        else $error("write-one did not clear pending bit");
    end
  endgenerate

  p_oe_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ((pad_oe & pad_od & pad_out) == '0))
    else $error("open-drain pad driven while high");

  p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq)
    else $error("interrupt without pending bit");

  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |=> (bus_rdata == 8'h00))
    else $error("unmapped read returned data");

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && $past(rst_n)) |=> $stable(bus_rdata))
    else $error("read data changed without a read");
endmodule

// File: tb/gpio_edge_ctrl_test.sv
module gpio_edge_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pad_out, pad_oe, pad_od, pull_en;
  logic [31:0] pull_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  gpio_edge_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .pull_en(pull_en),
    .pull_sel(pull_sel), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10: unexpected read result %0h", bus_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);

    rd_expect(8'h2B, 8'h00, "R1 drive reg");
    rd_expect(8'h33, 8'h00, "R1 sense reg");
    rd_expect(8'h0B, 8'h00, "R1 pending");
    rd_expect(8'h19, 8'h00, "R1 mask");
    rd_expect(8'h1C, 8'h00, "R1 aux mask");
    check(irq, 0, "R1 irq");
    check(pad_oe, 0, "R1 pad_oe");

    wr(8'h2E, 8'hFF);
    rd_expect(8'h2E, 8'h3F, "R2 drive bits 7:6 zero");
    check(pull_en[3], 1, "R2 pull_en");
    check(pull_sel[7:6], 2'd3, "R2 pull_sel");
    check(pad_od[3], 1, "R2 pad_od");
    check(pad_oe[3], 0, "R3 open-drain high not driven");
    wr(8'h2E, 8'h21);
    check(pad_oe[3], 1, "R3 push-pull driven");
    check(pad_out[3], 1, "R3 pad_out");
    wr(8'h2E, 8'h30);
    check(pad_oe[3], 1, "R3 open-drain low driven");
    check(pad_out[3], 0, "R3 pad_out low");
    wr(8'h2E, 8'h01);
    check(pad_oe[3], 0, "R3 input direction");
    wr(8'h3D, 8'h21);
    rd_expect(8'h3D, 8'h21, "R2 bank1 drive");
    check(pad_oe[10], 1, "R2 bank1 pad_oe");

    pin_in[5] = 1'b1;
    idle(4);
    rd_expect(8'h38, 8'h01, "R4 level");
    wr(8'h38, 8'hFF);
    rd_expect(8'h38, 8'h07, "R4 bits 7:3 zero");
    rd_expect(8'h0B, 8'h00, "R5 no edge no pending");
    wr(8'h38, 8'h00);

    wr(8'h34, 8'h04);
    pin_in[1] = 1'b1; idle(5);
    rd_expect(8'h0B, 8'h02, "R5 rising");
    check(irq, 1, "R7 irq on pending");
    wr(8'h0B, 8'h02);
    check(irq, 0, "R6 irq after clear");
    rd_expect(8'h0B, 8'h00, "R6 cleared");
    pin_in[1] = 1'b0; idle(5);
    rd_expect(8'h0B, 8'h00, "R5 falling ignored in rise mode");

    wr(8'h35, 8'h02);
    pin_in[2] = 1'b1; idle(5);
    rd_expect(8'h0B, 8'h00, "R5 rising ignored in fall mode");
    pin_in[2] = 1'b0; idle(5);
    rd_expect(8'h0B, 8'h04, "R5 falling");
    wr(8'h0B, 8'h04);

    wr(8'h44, 8'h06);
    pin_in[9] = 1'b1; idle(5);
    rd_expect(8'h0C, 8'h02, "R5 both rise");
    wr(8'h0C, 8'h02);
    pin_in[9] = 1'b0; idle(5);
    rd_expect(8'h0C, 8'h02, "R5 both fall");
    wr(8'h0C, 8'h02);

    pin_in[4] = 1'b1; idle(5);
    pin_in[4] = 1'b0; idle(5);
    rd_expect(8'h0B, 8'h00, "R5 mode off");

    wr(8'h1A, 8'h02);
    pin_in[9] = 1'b1; idle(5);
    rd_expect(8'h0C, 8'h02, "R7 masked still pending");
    check(irq, 0, "R7 masked irq low");
    wr(8'h1A, 8'h00);
    check(irq, 1, "R7 unmasked irq");
    wr(8'h0C, 8'h02);

    wr(8'h1B, 8'hFF);
    wr(8'h1C, 8'h5A);
    pin_in[9] = 1'b0; idle(5);
    check(irq, 1, "R8 aux mask no effect");
    rd_expect(8'h1B, 8'hFF, "R8 aux readback");
    rd_expect(8'h1C, 8'h5A, "R8 aux readback bank1");
    wr(8'h0C, 8'h02);

    pin_in[1] = 1'b1; idle(5);
    pin_in[2] = 1'b1; idle(5);
    pin_in[2] = 1'b0; idle(5);
    rd_expect(8'h0B, 8'h06, "R6 two pending");
    wr(8'h0B, 8'h02);
    rd_expect(8'h0B, 8'h04, "R6 partial clear");
    wr(8'h0B, 8'h04);

    pin_in[1] = 1'b0; idle(5);
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h0B; bus_wdata = 8'h02; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd_expect(8'h0B, 8'h02, "R6 set wins over clear");
    wr(8'h0B, 8'h02);

    wr(8'h4B, 8'hFF);
    wr(8'h00, 8'hFF);
    rd_expect(8'h4B, 8'h00, "R9 unmapped high");
    rd_expect(8'h00, 8'h00, "R9 unmapped zero");
    rd_expect(8'h2A, 8'h00, "R9 below drive range");
    rd_expect(8'h0B, 8'h00, "R9 pending untouched");
    rd_expect(8'h19, 8'h00, "R9 mask untouched");
    check(irq, 0, "R9 irq untouched");

    rd_expect(8'h3D, 8'h21, "R10 read value");
    wr(8'h3D, 8'h00);
    idle(2);
    check(bus_rdata, 8'h21, "R10 rdata holds");

    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule